// File: doc/BRIEF.md
# Power-Fail Early Warning Filter

This block turns the digitised output of an early-warning voltage comparator into an active-low interrupt. The interrupt tells a processor that its supply is about to fail. The comparator reads high while the monitored voltage is above its sense point and low when it has dropped below it. Supply noise can pull the comparator low for a short time. To reject it, the block looks at the comparator only once per sample period. It raises the interrupt only after a run of consecutive low samples. With the defaults this means the condition must last about three sample periods, or roughly 100 µs at a 30 kHz sample rate.

The comparator level first passes through a synchroniser. A parameterised divider makes a one-cycle sample tick from the system clock. Any high sample restarts the run of low samples. The interrupt clears on the first high sample after it was raised. A main-supply-good flag gates everything. While it is low, as during power-up before the main supply reaches its trip point, low readings are not counted and the interrupt is held inactive.

Top module: `pfw_filter`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `warn_n` is 1 and the count of low samples is zero.
- R2: The comparator is sampled once every `TICK_DIV` clock cycles. The first sample falls on the `TICK_DIV`-th edge after reset. The value sampled is the `cmp_ok` level delayed by `SYNC_STAGES` clock edges.
- R3: When `LOW_SAMPLES` (default 3) consecutive samples read 0 while `supply_ok` is 1, `warn_n` goes to 0 at the edge that takes the last of those samples. With fewer such samples it stays 1.
- R4: A sample that reads 1 resets the consecutive-low count to zero. So `LOW_SAMPLES-1` low samples, then one high sample, then `LOW_SAMPLES-1` more low samples leave `warn_n` at 1.
- R5: Once `warn_n` is 0, the first sample that reads 1 returns `warn_n` to 1 at the edge that takes that sample.
- R6: At every edge where `supply_ok` is 0, the low count is cleared and `warn_n` becomes 1. This takes precedence over a sample taken at the same edge, including the sample that would otherwise complete the run.
- R7: After `supply_ok` returns to 1, the count restarts from zero. Low samples taken before or during the supply loss do not count toward the run.
- R8: While `supply_ok` is 1, `warn_n` changes only at edges that take a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_ok | input | 1 | Comparator level, asynchronous: 1 = monitored voltage above sense point, 0 = below |
| supply_ok | input | 1 | Main supply above its trip point, synchronous to `clk` |
| warn_n | output | 1 | Active-low power-fail early warning interrupt |

## Verification
Two events can fall on the same clock edge. One is the sample that would complete the run of low readings. The other is the main supply going bad, which must win. The bench tracks the divider phase in its own model. It drops `supply_ok` in the cycle just before the edge that takes the completing low sample. The check is that `warn_n` stays high, and that a full new run of low samples is needed after the supply returns. A second case drops the supply while the warning is already raised, between samples. The check there is that the warning clears at the very next edge and does not wait for a sample.

// File: rtl/pfw_pkg.sv
// Package: shared types and helpers for the power-fail warning filter.
// Assumes: nothing beyond IEEE 1800-2017.
package pfw_pkg;

    // Filter phase, used for readability of the run counter logic.
    typedef enum logic [1:0] {
        PH_QUIET = 2'd0,  // no low sample pending
        PH_RUN   = 2'd1,  // counting consecutive low samples
        PH_WARN  = 2'd2   // warning raised
    } pfw_phase_e;

    // Width needed to hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/pfw_sync.sv
// Module: multi-flop synchroniser for the asynchronous comparator level.
// Assumes: STAGES >= 2; reset value is the "good" level so that a reset
// never produces a spurious low reading.
module pfw_sync #(
    parameter int unsigned STAGES   = 2,
    parameter bit          RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pfw_tick.sv
// Module: free-running divider producing a one-cycle sample tick.
// Assumes: DIV >= 2; the tick is high in the last cycle of each period,
// so the first tick edge is the DIV-th edge after reset.
module pfw_tick #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DW = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Count clock cycles modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/pfw_run.sv
// Module: consecutive-low-sample counter with output register.
// Assumes: 'sample' is already synchronous; 'tick' is a one-cycle pulse;
// 'gate' low means main supply bad and overrides everything.
module pfw_run #(
    parameter int unsigned NEED = 3,
    localparam int unsigned CW  = pfw_pkg::cnt_width(NEED)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate,
    input  logic          tick,
    input  logic          sample,
    output logic [CW-1:0] run_cnt,
    output logic          warn_n
);
    import pfw_pkg::*;

    localparam logic [CW-1:0] FULL = CW'(NEED);

    pfw_phase_e    phase_q, phase_d;
    logic [CW-1:0] cnt_d;

    // Next-state: supply gate first, then per-sample update.
    always_comb begin
        cnt_d   = run_cnt;
        phase_d = phase_q;
        if (!gate) begin
            cnt_d   = '0;
            phase_d = PH_QUIET;
        end else if (tick) begin
            if (sample) begin
                cnt_d   = '0;
                phase_d = PH_QUIET;
            end else begin
                if (run_cnt != FULL) begin
                    cnt_d = run_cnt + 1'b1;
                end
                phase_d = (cnt_d == FULL) ? PH_WARN : PH_RUN;
            end
        end
    end

    // Register count, phase and the active-low output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            phase_q <= PH_QUIET;
            warn_n  <= 1'b1;
        end else begin
            run_cnt <= cnt_d;
            phase_q <= phase_d;
            warn_n  <= (phase_d != PH_WARN);
        end
    end
endmodule

// File: rtl/pfw_filter.sv
// Module: top of the power-fail early warning filter.
// Assumes: cmp_ok is asynchronous (1 = above sense point); supply_ok is
// synchronous to clk. Output warn_n is registered, active low.
module pfw_filter #(
    parameter int unsigned TICK_DIV    = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned LOW_SAMPLES = 3,
    localparam int unsigned CW = pfw_pkg::cnt_width(LOW_SAMPLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_ok,
    input  logic supply_ok,
    output logic warn_n
);
    logic          cmp_s;
    logic          tick;
    logic [CW-1:0] run_cnt;

    pfw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_ok),
        .q_sync  (cmp_s)
    );

    pfw_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pfw_run #(.NEED(LOW_SAMPLES)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (supply_ok),
        .tick    (tick),
        .sample  (cmp_s),
        .run_cnt (run_cnt),
        .warn_n  (warn_n)
    );
endmodule

// File: rtl/pfw_filter_chk.sv
// Module: assertion checker bound to pfw_filter.
// Assumes: observes the top's ports and the signals between its sub-blocks.
module pfw_filter_chk #(
    parameter int unsigned NEED = 3,
    parameter int unsigned CW   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_ok,
    input logic          tick,
    input logic          cmp_s,
    input logic [CW-1:0] run_cnt,
    input logic          warn_n
);
    // R6
    supply_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (warn_n && run_cnt == '0));

    // R3
    run_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && tick && !cmp_s && run_cnt == CW'(NEED - 1)) |=> !warn_n);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && tick && cmp_s) |=> warn_n);

    // R4
    run_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && tick && cmp_s) |=> (run_cnt == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !tick) |=> $stable(warn_n));

    // R2
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(NEED));
endmodule

bind pfw_filter pfw_filter_chk #(.NEED(LOW_SAMPLES), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .tick      (tick),
    .cmp_s     (cmp_s),
    .run_cnt   (run_cnt),
    .warn_n    (warn_n)
);

// File: tb/tb_pfw_filter.sv
module tb_pfw_filter;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 16;
    localparam int SYNC = 2;
    localparam int NEED = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_ok = 1'b1;
    logic supply_ok = 1'b0;
    logic warn_n;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_div;
    int m_run;
    bit m_warn_n;
    bit m_hist[$];

    pfw_filter #(.TICK_DIV(DIV), .SYNC_STAGES(SYNC), .LOW_SAMPLES(NEED)) dut (
        .clk(clk), .rst_n(rst_n), .cmp_ok(cmp_ok),
        .supply_ok(supply_ok), .warn_n(warn_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s warn_n actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin
        bit tk;
        bit s;
        if (!rst_n) begin
            m_div = 0; m_run = 0; m_warn_n = 1'b1;
            m_hist.delete();
            for (int i = 0; i < SYNC; i++) m_hist.push_back(1'b1);
        end else begin
            tk = (m_div == DIV - 1);
            s = m_hist[0];
            if (!supply_ok) begin
                m_run = 0; m_warn_n = 1'b1;
            end else if (tk) begin
                if (s) begin
                    m_run = 0; m_warn_n = 1'b1;
                end else begin
                    if (m_run < NEED) m_run++;
                    if (m_run == NEED) m_warn_n = 1'b0;
                end
            end
            void'(m_hist.pop_front());
            m_hist.push_back(cmp_ok);
            m_div = tk ? 0 : m_div + 1;
        end
    end

    // Compare against the model on every cycle, away from the edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && cycles > 2) check(cur_req, warn_n, m_warn_n);
    end

    // Stop at the negedge just after the next sample edge.
    task automatic tick_step();
        do @(negedge clk); while (m_div != DIV - 1);
        @(negedge clk);
    endtask

    // Stop at the negedge just before the next sample edge.
    task automatic to_pre_tick();
        do @(negedge clk); while (m_div != DIV - 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", warn_n, 1'b1);

        // R6: supply bad, long low comparator, no warning
        cur_req = "R6";
        cmp_ok = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick_step();
            check("R6", warn_n, 1'b1);
        end

        // R3: supply good, three lows needed
        cur_req = "R3";
        cmp_ok = 1'b1; supply_ok = 1'b1;
        tick_step(); tick_step();
        cmp_ok = 1'b0;
        tick_step(); check("R3", warn_n, 1'b1);
        tick_step(); check("R3", warn_n, 1'b1);
        to_pre_tick(); check("R2", warn_n, 1'b1);
        @(negedge clk); check("R3", warn_n, 1'b0);

        // R5/R8: clear on first high sample, held until then
        cur_req = "R5";
        cmp_ok = 1'b1;
        to_pre_tick(); check("R8", warn_n, 1'b0);
        @(negedge clk); check("R5", warn_n, 1'b1);

        // R4: two lows, a high, two lows -> no warning
        cur_req = "R4";
        cmp_ok = 1'b0; tick_step(); tick_step();
        cmp_ok = 1'b1; tick_step();
        cmp_ok = 1'b0; tick_step(); tick_step();
        check("R4", warn_n, 1'b1);
        tick_step(); check("R4", warn_n, 1'b0);

        // R6: supply loss while warning raised, between samples
        cur_req = "R6";
        repeat (3) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk); check("R6", warn_n, 1'b1);
        supply_ok = 1'b1;
        cmp_ok = 1'b1; tick_step();

        // R6: supply loss on the edge that would complete the run
        cmp_ok = 1'b0;
        tick_step(); tick_step();
        to_pre_tick();
        supply_ok = 1'b0;
        @(negedge clk); check("R6", warn_n, 1'b1);
        supply_ok = 1'b1;

        // R7: count restarts after supply returns
        cur_req = "R7";
        tick_step(); check("R7", warn_n, 1'b1);
        tick_step(); check("R7", warn_n, 1'b1);
        tick_step(); check("R7", warn_n, 0);

        // R1: reset while warning raised
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); check("R1", warn_n, 1'b1);
        rst_n = 1'b1; cmp_ok = 1'b1;
        repeat (2 * DIV) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule